// File: doc/BRIEF.md
# eBPF Integer ALU with Byte Swap

This block carries out one integer operation of the eBPF register machine on 64-bit operands: arithmetic, logic, shifts, moves, negation, unsigned division and remainder, and the endianness conversion. The decoder supplies the operation code, the class bit (32-bit or 64-bit), the source-select bit, the current destination register value, the source register value and the 32-bit immediate. The block returns the new destination value together with a done pulse, and it raises a trap flag for encodings that are not valid ALU operations.

An operation begins with a one-cycle `start`. All operations except division and remainder finish in one registered cycle. Division and remainder use a radix-2 restoring divider that holds `busy` high while it runs. A new `start` is accepted only while `busy` is low. The byte order of the host is a parameter, and the conversion swaps bytes only when the requested order differs from it.

Top module: `ebpf_alu_core`

## Requirements
- R1: After reset, and until the first accepted start, `done`, `busy` and `trap` are 0 and `result` is 0.
- R2: With `src_sel`=0 the second operand is the 32-bit immediate sign-extended to 64 bits. With `src_sel`=1 it is `src_val`.
- R3: With `is64`=1 the operation codes ADD=0, SUB=1, MUL=2 (low 64 bits of the product), OR=4, AND=5, XOR=0xA and MOV=0xB (result is the second operand) work on all 64 bits. NEG=8 returns the two's complement of `dst_val` and ignores the second operand.
- R4: With `is64`=0 every operation except END works on bits [31:0] of both operands as unsigned values, and the result is zero-extended, so `result[63:32]` is 0.
- R5: LSH=6 and RSH=7 are logical shifts and ARSH=0xC is an arithmetic shift of `dst_val`. The shift amount is the second operand masked to 6 bits in the 64-bit class and to 5 bits in the 32-bit class.
- R6: DIV=3 and MOD=9 are unsigned. A zero divisor makes DIV return 0 and MOD return the dividend unchanged.
- R7: END=0xD in the 32-bit class converts `dst_val`. `src_sel`=0 requests little-endian and `src_sel`=1 requests big-endian. The immediate 16, 32 or 64 selects the width. Bytes inside that width are reversed only when the requested order differs from HOST_BIG_ENDIAN (default 0, little-endian). The bits above the width are cleared.
- R8: The following encodings raise `trap` with `done` and return `dst_val` unchanged: NEG in the 32-bit class with `src_sel`=1; END in the 64-bit class; END with an immediate other than 16, 32 or 64; and operation codes 0xE and 0xF.
- R9: For every operation other than a non-trapping DIV or MOD, `done` and `result` appear in the cycle after the start cycle. A non-trapping DIV or MOD raises `busy` from the cycle after start and delivers `done` XLEN+1 cycles after the start cycle, in the same cycle that `busy` falls.
- R10: A `start` while `busy` is high is ignored: it produces no `done` of its own and leaves the running result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to execute the presented operation |
| op_code | input | 4 | Operation code |
| is64 | input | 1 | 1 selects the 64-bit class, 0 the 32-bit class |
| src_sel | input | 1 | 0 selects the immediate, 1 the source register; for END it selects the byte order |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| busy | output | 1 | Divider running; start is ignored |
| done | output | 1 | Result valid for one cycle |
| trap | output | 1 | The operation was an invalid encoding; valid with done |
| result | output | 64 | New destination value |

## Verification
Single-cycle operations, and every trap, are due in the cycle after the start cycle. Non-trapping division and remainder are due XLEN+1 cycles after it. The bench samples on falling edges and counts the cycles from the start cycle until `done` appears. It compares that count with the latency expected for the operation, and it reads `result` and `trap` in that same cycle. For the ignored-start case, the bench also checks that `done` does not appear in the cycle where the stray request would have finished, and that it stays low after the real completion.

// File: rtl/ebpf_alu_pkg.sv
// Shared operation codes for the eBPF integer ALU.
// Assumes a 4-bit operation code field.
package ebpf_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_ARSH = 4'hC,
        OP_END  = 4'hD,
        OP_RSV0 = 4'hE,
        OP_RSV1 = 4'hF
    } alu_op_e;
endpackage

// File: rtl/ebpf_alu_operand.sv
// Second-operand select: either the sign-extended immediate or the source register.
// Assumes XLEN > IMM_W.
module ebpf_alu_operand #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic             src_sel,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  op_b
);
    localparam int EXT_W = XLEN - IMM_W;

    // Pick the register or the widened immediate.
    always_comb begin
        op_b = src_sel ? src_val : {{EXT_W{imm[IMM_W-1]}}, imm};
    end
endmodule

// File: rtl/ebpf_alu_exec.sv
// Single-cycle arithmetic, logic, shift and move unit for both classes.
// Assumes HALF < XLEN and both are powers of two; the 32-bit class result is zero-extended.
module ebpf_alu_exec
    import ebpf_alu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  alu_op_e         op,
    input  logic            is64,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);
    localparam int SH_W = $clog2(XLEN);
    localparam int SH_H = $clog2(HALF);

    logic [XLEN-1:0] wide_r;
    logic [HALF-1:0] narrow_r;
    logic [HALF-1:0] a_n;
    logic [HALF-1:0] b_n;
    logic [SH_W-1:0] sh_w;
    logic [SH_H-1:0] sh_n;

    // Full-width result of the operation.
    always_comb begin
        sh_w = b[SH_W-1:0];
        case (op)
            OP_ADD:  wide_r = a + b;
            OP_SUB:  wide_r = a - b;
            OP_MUL:  wide_r = a * b;
            OP_OR:   wide_r = a | b;
            OP_AND:  wide_r = a & b;
            OP_LSH:  wide_r = a << sh_w;
            OP_RSH:  wide_r = a >> sh_w;
            OP_NEG:  wide_r = -a;
            OP_XOR:  wide_r = a ^ b;
            OP_MOV:  wide_r = b;
            OP_ARSH: wide_r = $unsigned($signed(a) >>> sh_w);
            default: wide_r = a;
        endcase
    end

    // Low-half result on the truncated operands.
    always_comb begin
        a_n  = a[HALF-1:0];
        b_n  = b[HALF-1:0];
        sh_n = b[SH_H-1:0];
        case (op)
            OP_ADD:  narrow_r = a_n + b_n;
            OP_SUB:  narrow_r = a_n - b_n;
            OP_MUL:  narrow_r = a_n * b_n;
            OP_OR:   narrow_r = a_n | b_n;
            OP_AND:  narrow_r = a_n & b_n;
            OP_LSH:  narrow_r = a_n << sh_n;
            OP_RSH:  narrow_r = a_n >> sh_n;
            OP_NEG:  narrow_r = -a_n;
            OP_XOR:  narrow_r = a_n ^ b_n;
            OP_MOV:  narrow_r = b_n;
            OP_ARSH: narrow_r = $unsigned($signed(a_n) >>> sh_n);
            default: narrow_r = a_n;
        endcase
    end

    // Class select with zero extension of the narrow result.
    always_comb begin
        res = is64 ? wide_r : {{(XLEN-HALF){1'b0}}, narrow_r};
    end
endmodule

// File: rtl/ebpf_alu_bswap.sv
// Endianness conversion over 16, 32 or 64 bits with the upper bits cleared.
// Assumes XLEN is 64; bytes are reversed only when the requested order differs from the host order.
module ebpf_alu_bswap #(
    parameter int   XLEN     = 64,
    parameter int   IMM_W    = 32,
    parameter logic HOST_BIG = 1'b0
) (
    input  logic [XLEN-1:0]  value,
    input  logic [IMM_W-1:0] width_sel,
    input  logic             to_big,
    output logic [XLEN-1:0]  res,
    output logic             bad_width
);
    localparam int N_SIZES = 3;

    logic [XLEN-1:0] swp [N_SIZES];
    logic [XLEN-1:0] pln [N_SIZES];
    logic            do_swap;

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int W  = 16 << g;
        localparam int NB = W / 8;
        for (genvar k = 0; k < NB; k++) begin : g_byte
            assign swp[g][k*8 +: 8] = value[(NB-1-k)*8 +: 8];
        end
        assign pln[g][W-1:0] = value[W-1:0];
        if (W < XLEN) begin : g_clear
            assign swp[g][XLEN-1:W] = '0;
            assign pln[g][XLEN-1:W] = '0;
        end
    end

    // Width decode and order select.
    always_comb begin
        do_swap   = to_big ^ HOST_BIG;
        bad_width = 1'b0;
        case (width_sel)
            IMM_W'(16): res = do_swap ? swp[0] : pln[0];
            IMM_W'(32): res = do_swap ? swp[1] : pln[1];
            IMM_W'(64): res = do_swap ? swp[2] : pln[2];
            default: begin
                res       = value;
                bad_width = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ebpf_alu_divider.sv
// Radix-2 restoring unsigned divider, one quotient bit per cycle, XLEN steps.
// Assumes load is only pulsed while busy is low; a zero divisor forces the quotient to zero,
// and the remainder then naturally equals the dividend.
module ebpf_alu_divider #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            busy,
    output logic            last,
    output logic [XLEN-1:0] quo_out,
    output logic [XLEN-1:0] rem_out
);
    localparam int CNT_W = $clog2(XLEN + 1);

    logic [XLEN-1:0]  rem_q, quo_q, dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, zero_q;
    logic [XLEN:0]    shifted, diff;
    logic [XLEN-1:0]  rem_nx, quo_nx;

    // One restoring step: trial subtract, keep it when no borrow.
    always_comb begin
        shifted = {rem_q, quo_q[XLEN-1]};
        diff    = shifted - {1'b0, dvs_q};
        rem_nx  = diff[XLEN] ? shifted[XLEN-1:0] : diff[XLEN-1:0];
        quo_nx  = {quo_q[XLEN-2:0], ~diff[XLEN]};
    end

    // Iteration state and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            zero_q <= 1'b0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dvs_q  <= divisor;
            cnt_q  <= CNT_W'(XLEN);
            busy_q <= 1'b1;
            zero_q <= (divisor == '0);
        end else if (busy_q) begin
            rem_q  <= rem_nx;
            quo_q  <= quo_nx;
            cnt_q  <= cnt_q - CNT_W'(1);
            busy_q <= (cnt_q != CNT_W'(1));
        end
    end

    assign busy    = busy_q;
    assign last    = busy_q && (cnt_q == CNT_W'(1));
    assign quo_out = zero_q ? '0 : quo_nx;
    assign rem_out = rem_nx;
endmodule

// File: rtl/ebpf_alu_core.sv
// eBPF integer ALU top: operand select, single-cycle unit, byte swap, iterative divider, trap decode.
// Assumes start is a one-cycle request; a start while busy is dropped.
module ebpf_alu_core
    import ebpf_alu_pkg::*;
#(
    parameter int   XLEN            = 64,
    parameter int   HALF            = 32,
    parameter int   IMM_W           = 32,
    parameter logic HOST_BIG_ENDIAN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       op_code,
    input  logic             is64,
    input  logic             src_sel,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    output logic             busy,
    output logic             done,
    output logic             trap,
    output logic [XLEN-1:0]  result
);
    alu_op_e         op;
    logic [XLEN-1:0] op_b, exec_res, swap_res, dvd, dvs, quo, rem;
    logic            bad_width, is_div, trap_now, accept, div_load, div_last;
    logic            mod_q, done_q, trap_q;
    logic [XLEN-1:0] result_q;

    ebpf_alu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_operand (
        .src_sel(src_sel), .src_val(src_val), .imm(imm), .op_b(op_b)
    );

    ebpf_alu_exec #(.XLEN(XLEN), .HALF(HALF)) u_exec (
        .op(op), .is64(is64), .a(dst_val), .b(op_b), .res(exec_res)
    );

    ebpf_alu_bswap #(.XLEN(XLEN), .IMM_W(IMM_W), .HOST_BIG(HOST_BIG_ENDIAN)) u_bswap (
        .value(dst_val), .width_sel(imm), .to_big(src_sel),
        .res(swap_res), .bad_width(bad_width)
    );

    ebpf_alu_divider #(.XLEN(XLEN)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_load), .dividend(dvd), .divisor(dvs),
        .busy(busy), .last(div_last), .quo_out(quo), .rem_out(rem)
    );

    // Decode of the request: trap conditions and divider operands.
    always_comb begin
        op       = alu_op_e'(op_code);
        is_div   = (op == OP_DIV) || (op == OP_MOD);
        trap_now = (op == OP_RSV0) || (op == OP_RSV1)
                || (!is64 && src_sel && (op == OP_NEG))
                || ((op == OP_END) && (is64 || bad_width));
        accept   = start && !busy;
        div_load = accept && is_div && !trap_now;
        dvd      = is64 ? dst_val : {{(XLEN-HALF){1'b0}}, dst_val[HALF-1:0]};
        dvs      = is64 ? op_b    : {{(XLEN-HALF){1'b0}}, op_b[HALF-1:0]};
    end

    // Result register, done pulse and trap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
            trap_q   <= 1'b0;
            mod_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            if (accept) begin
                mod_q <= (op == OP_MOD);
                if (trap_now) begin
                    result_q <= dst_val;
                    done_q   <= 1'b1;
                    trap_q   <= 1'b1;
                end else if (!is_div) begin
                    result_q <= (op == OP_END) ? swap_res : exec_res;
                    done_q   <= 1'b1;
                end
            end
            if (div_last) begin
                result_q <= mod_q ? rem : quo;
                done_q   <= 1'b1;
            end
        end
    end

    assign done   = done_q;
    assign trap   = trap_q;
    assign result = result_q;
endmodule

// File: rtl/ebpf_alu_checker.sv
// Protocol and result-shape checks for ebpf_alu_core, bound to every instance.
// Assumes the synchronous active-low reset of the core.
module ebpf_alu_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [3:0]      op_code,
    input logic            is64,
    input logic            busy,
    input logic            done,
    input logic            trap,
    input logic [XLEN-1:0] result
);
    localparam int CNT_W = $clog2(XLEN + 2);

    logic             narrow_q;
    logic [CNT_W-1:0] busy_cnt;

    // Remember the class of the last accepted request and time the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            narrow_q <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (start && !busy) narrow_q <= !is64 && (op_code != 4'hD);
            busy_cnt <= busy ? busy_cnt + CNT_W'(1) : '0;
        end
    end

    assert_trap_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> done);

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start) || $past(busy)));

    assert_fall_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_busy_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(XLEN));

    assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));

    assert_narrow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && narrow_q && !trap) |-> (result[XLEN-1:32] == '0));
endmodule

bind ebpf_alu_core ebpf_alu_checker #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .is64(is64),
    .busy(busy), .done(done), .trap(trap), .result(result)
);

// File: tb/tb_ebpf_alu_core.sv
module tb_ebpf_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_code = '0;
    logic        is64 = 1'b0;
    logic        src_sel = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic        busy, done, trap;
    logic [63:0] result;

    int n_checks = 0;
    int n_err = 0;

    localparam int DIV_LAT = 65;

    ebpf_alu_core dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .is64(is64),
        .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .busy(busy), .done(done), .trap(trap), .result(result)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model: returns {trap, result}.
    function automatic logic [64:0] model(input logic [3:0] op, input logic w64, input logic sel,
                                          input logic [63:0] d, input logic [63:0] s,
                                          input logic [31:0] im);
        logic [63:0] b, r;
        logic [31:0] d32, b32, r32;
        int nb;
        b   = sel ? s : {{32{im[31]}}, im};
        d32 = d[31:0];
        b32 = b[31:0];
        r   = '0;
        r32 = '0;
        if (op > 4'hD || (!w64 && sel && op == 4'h8) ||
            (op == 4'hD && (w64 || !(im == 16 || im == 32 || im == 64))))
            return {1'b1, d};
        if (op == 4'hD) begin
            nb = int'(im) / 8;
            for (int k = 0; k < nb; k++)
                r[k*8 +: 8] = sel ? d[(nb-1-k)*8 +: 8] : d[k*8 +: 8];
            return {1'b0, r};
        end
        if (w64) begin
            case (op)
                4'h0: r = d + b;
                4'h1: r = d - b;
                4'h2: r = d * b;
                4'h3: r = (b == 0) ? 64'd0 : d / b;
                4'h4: r = d | b;
                4'h5: r = d & b;
                4'h6: r = d << b[5:0];
                4'h7: r = d >> b[5:0];
                4'h8: r = -d;
                4'h9: r = (b == 0) ? d : d % b;
                4'hA: r = d ^ b;
                4'hB: r = b;
                default: r = $unsigned($signed(d) >>> b[5:0]);
            endcase
            return {1'b0, r};
        end
        case (op)
            4'h0: r32 = d32 + b32;
            4'h1: r32 = d32 - b32;
            4'h2: r32 = d32 * b32;
            4'h3: r32 = (b32 == 0) ? 32'd0 : d32 / b32;
            4'h4: r32 = d32 | b32;
            4'h5: r32 = d32 & b32;
            4'h6: r32 = d32 << b32[4:0];
            4'h7: r32 = d32 >> b32[4:0];
            4'h8: r32 = -d32;
            4'h9: r32 = (b32 == 0) ? d32 : d32 % b32;
            4'hA: r32 = d32 ^ b32;
            4'hB: r32 = b32;
            default: r32 = $unsigned($signed(d32) >>> b32[4:0]);
        endcase
        return {1'b0, 32'd0, r32};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic w64, input logic t);
        if (t) return "R8";
        if (op == 4'h3 || op == 4'h9) return "R6";
        if (op == 4'h6 || op == 4'h7 || op == 4'hC) return "R5";
        if (op == 4'hD) return "R7";
        return w64 ? "R3" : "R4";
    endfunction

    // Issue one request and check latency, result and trap in the done cycle.
    task automatic run_op(input logic [3:0] op, input logic w64, input logic sel,
                          input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                          input logic exp_trap, input logic [63:0] exp_res, input int exp_lat,
                          input string tag);
        int lat;
        @(negedge clk);
        op_code = op; is64 = w64; src_sel = sel; dst_val = d; src_val = s; imm = im;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " R9 latency"}, 64'(lat), 64'(exp_lat));
        check(result == exp_res, {tag, " result"}, result, exp_res);
        check(trap == exp_trap, {tag, " trap"}, 64'(trap), 64'(exp_trap));
    endtask

    task automatic run_model(input logic [3:0] op, input logic w64, input logic sel,
                             input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
        logic [64:0] m;
        int lat;
        m   = model(op, w64, sel, d, s, im);
        lat = (!m[64] && (op == 4'h3 || op == 4'h9)) ? DIV_LAT : 1;
        run_op(op, w64, sel, d, s, im, m[64], m[63:0], lat, tag_of(op, w64, m[64]));
    endtask

    initial begin
        #1ms;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [63:0] pat;
        void'($urandom(32'd20240611));
        pat = 64'h1122334455667788;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!done && !busy && !trap, "R1 flags", {61'd0, done, busy, trap}, 64'd0);
        check(result == 64'd0, "R1 result", result, 64'd0);

        // R2 operand select
        run_op(4'h0, 1'b1, 1'b0, 64'd5, 64'd100, 32'hFFFF_FFFF, 1'b0, 64'd4, 1, "R2 imm");
        run_op(4'h0, 1'b1, 1'b1, 64'd5, 64'd100, 32'hFFFF_FFFF, 1'b0, 64'd105, 1, "R2 reg");
        // R3 full width, NEG ignores source
        run_op(4'hB, 1'b1, 1'b0, 64'd0, 64'd0, 32'hFFFF_FFFE, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1, "R3 mov");
        run_op(4'h8, 1'b1, 1'b1, 64'd1, 64'hDEAD, 32'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R3 neg");
        // R4 narrow class
        run_op(4'h0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 1'b0, 64'd0, 1, "R4 add wrap");
        run_op(4'hB, 1'b0, 1'b0, 64'd0, 64'd0, 32'hFFFF_FFFE, 1'b0, 64'h0000_0000_FFFF_FFFE, 1, "R4 mov");
        // R5 shifts and masking
        run_op(4'h6, 1'b1, 1'b0, 64'd3, 64'd0, 32'd65, 1'b0, 64'd6, 1, "R5 lsh64 mask");
        run_op(4'h6, 1'b0, 1'b0, 64'd3, 64'd0, 32'd33, 1'b0, 64'd6, 1, "R5 lsh32 mask");
        run_op(4'hC, 1'b0, 1'b0, 64'h8000_0000, 64'd0, 32'd4, 1'b0, 64'hF800_0000, 1, "R5 arsh32");
        run_op(4'h7, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'd0, 32'd63, 1'b0, 64'd1, 1, "R5 rsh64");
        // R6 division
        run_op(4'h3, 1'b1, 1'b1, 64'd100, 64'd7, 32'd0, 1'b0, 64'd14, DIV_LAT, "R6 div");
        run_op(4'h9, 1'b1, 1'b1, 64'd100, 64'd7, 32'd0, 1'b0, 64'd2, DIV_LAT, "R6 mod");
        run_op(4'h3, 1'b1, 1'b1, 64'd123, 64'd0, 32'd0, 1'b0, 64'd0, DIV_LAT, "R6 div zero");
        run_op(4'h9, 1'b1, 1'b1, 64'd123, 64'd0, 32'd0, 1'b0, 64'd123, DIV_LAT, "R6 mod zero");
        run_op(4'h3, 1'b0, 1'b1, 64'h5_0000_0064, 64'h9_0000_000A, 32'd0, 1'b0, 64'd10, DIV_LAT, "R6 div32");
        // R7 byte order conversion
        run_op(4'hD, 1'b0, 1'b0, pat, 64'd0, 32'd16, 1'b0, 64'h7788, 1, "R7 le16");
        run_op(4'hD, 1'b0, 1'b1, pat, 64'd0, 32'd16, 1'b0, 64'h8877, 1, "R7 be16");
        run_op(4'hD, 1'b0, 1'b1, pat, 64'd0, 32'd32, 1'b0, 64'h8877_6655, 1, "R7 be32");
        run_op(4'hD, 1'b0, 1'b1, pat, 64'd0, 32'd64, 1'b0, 64'h8877_6655_4433_2211, 1, "R7 be64");
        run_op(4'hD, 1'b0, 1'b0, pat, 64'd0, 32'd64, 1'b0, pat, 1, "R7 le64");
        // R8 traps
        run_op(4'h8, 1'b0, 1'b1, pat, 64'd0, 32'd0, 1'b1, pat, 1, "R8 neg reg");
        run_op(4'hD, 1'b1, 1'b0, pat, 64'd0, 32'd16, 1'b1, pat, 1, "R8 end64");
        run_op(4'hD, 1'b0, 1'b0, pat, 64'd0, 32'd8, 1'b1, pat, 1, "R8 end width");
        run_op(4'hE, 1'b1, 1'b1, pat, 64'd0, 32'd0, 1'b1, pat, 1, "R8 rsv");
        run_op(4'h3, 1'b1, 1'b0, pat, 64'd0, 32'd0, 1'b0, 64'd0, DIV_LAT, "R8 nontrap div imm0");

        // R10 start while busy is ignored
        begin
            int lat;
            @(negedge clk);
            op_code = 4'h3; is64 = 1'b1; src_sel = 1'b1; dst_val = 64'd1000; src_val = 64'd10;
            start = 1'b1;
            @(negedge clk);
            op_code = 4'h0; dst_val = 64'd1; src_val = 64'd1;
            lat = 1;
            @(negedge clk);
            start = 1'b0;
            lat = 2;
            check(!done, "R10 stray done", 64'(done), 64'd0);
            while (!done && lat < 200) begin
                @(negedge clk);
                lat++;
            end
            check(lat == DIV_LAT, "R10 latency", 64'(lat), 64'(DIV_LAT));
            check(result == 64'd100, "R10 result", result, 64'd100);
            @(negedge clk);
            check(!done, "R10 no extra done", 64'(done), 64'd0);
        end

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  op;
            logic        w64, sel;
            logic [63:0] d, s;
            logic [31:0] im;
            op  = 4'($urandom_range(0, 15));
            w64 = 1'($urandom);
            sel = 1'($urandom);
            d   = {$urandom, $urandom};
            s   = ($urandom_range(0, 7) == 0) ? 64'd0 : {$urandom, $urandom};
            im  = $urandom;
            if ($urandom_range(0, 3) == 0) d = d >> $urandom_range(0, 63);
            if (op == 4'hD && $urandom_range(0, 3) != 0) begin
                w64 = 1'b0;
                im  = 32'd16 << $urandom_range(0, 2);
            end
            run_model(op, w64, sel, d, s, im);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule